// File: doc/BRIEF.md
# Two-Agent Symmetric Bus Request Arbiter

This block is the request side of one of two symmetric agents on a shared processor bus. Each agent has two active-low request pins. The board wires them to two shared request lines in a rotated pattern, so each agent always drives its own line from its pin 0 and sees the other agent's line on its pin 1. While bus reset is held, a central agent pulls shared request line 0 low. When reset is released, the agent looks at which of its pins is low and takes its agent ID from that.

After configuration, the two agents pass bus ownership between them in round-robin fashion. The owner keeps the bus as long as its request line stays active. Ownership moves to the other agent once the owner releases its line while the other agent is requesting. The local request queue gets a grant when this agent owns the bus and is requesting. A high-priority agent can override the grant. A locked sequence that has already started may continue under that override.

Top module: `sym_breq_agent`

## Requirements
- R1: While `rst_n` is low, and until `cfg_done` is high, `br0_drive_n` is 1, `grant` is 0 and `cfg_done` is 0, whatever `req_i` does.
- R2: `rst_n` is released through a two-stage synchronizer. `cfg_done` is still 0 after the second rising edge following the release of `rst_n`, and is 1 after the third. On that third edge the pins are latched: if only pin 0 (`br_in_n[0]`) is low, `agent_id` becomes 0; if only pin 1 (`br_in_n[1]`) is low, `agent_id` becomes 1.
- R3: If both pins or neither pin are low on the latch edge, `cfg_err` becomes 1 and `agent_id` becomes 0. Otherwise `cfg_err` becomes 0.
- R4: `agent_id` and `cfg_err` do not change again until the next reset, whatever the pins do.
- R5: After configuration, `br0_drive_n` equals the inverse of `req_i`. Shared request line k is observed on pin (k XOR `agent_id`), so the agent's own line is pin 0 and the other agent's line is pin 1.
- R6: Immediately after configuration, `owner_id` is 1, which gives agent 0 the first hand-over.
- R7: On each rising edge after configuration, ownership changes only when the owner's shared request line is inactive and the other line is active. It then passes to the other agent. In every other case `owner_id` holds.
- R8: `grant` is high exactly when `cfg_done` is high, `owner_id` equals `agent_id`, the agent's own request line is observed active, `req_i` is high, and the priority gate (R9) is open. `grant` is combinational on these inputs.
- R9: While `bpri_n` is low, `grant` is 0 unless the lock exception (R10) applies.
- R10: The lock exception applies when `lock_i` is high and a grant was already given while `lock_i` was high, with `lock_i` not dropping in between. A locked sequence whose first grant has not yet happened is blocked by `bpri_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous assert |
| br_in_n | input | 2 | Observed levels of the two request pins, active low |
| bpri_n | input | 1 | Priority agent request, active low |
| req_i | input | 1 | Local queue wants the bus |
| lock_i | input | 1 | Local queue is inside a locked sequence |
| br0_drive_n | output | 1 | Drive level for own request pin 0, active low |
| grant | output | 1 | Local queue may issue now |
| agent_id | output | 1 | Agent ID latched at configuration |
| cfg_done | output | 1 | Configuration complete |
| cfg_err | output | 1 | Pin pattern at configuration was invalid |
| owner_id | output | 1 | Agent that currently owns the bus |

## Verification
A wrong latched ID shows as `agent_id` on the cycle after the latch edge. It also inverts the pin-to-line mapping, so ownership then follows the wrong pin on the next edge. A bad owner register shows as `owner_id` one edge after the request pattern that should have moved or held it, and `grant` follows in the same cycle. A wrong lock-tracking state only shows when `bpri_n` is low: `grant` then comes up or stays down in the same cycle as `req_i`, against the R10 rule.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int N_AGENTS = 2;
  localparam int ID_W     = $clog2(N_AGENTS);
  typedef logic [ID_W-1:0] agent_id_t;
endpackage

// File: rtl/sba_rst_sync.sv
module sba_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/sba_id_cfg.sv
module sba_id_cfg
  import sba_pkg::*;
(
  input  logic                clk,
  input  logic                rst_int_n,
  input  logic [N_AGENTS-1:0] br_in_n,
  output logic                cfg_done,
  output agent_id_t           agent_id,
  output logic                cfg_err
);
  logic      load_en;
  agent_id_t id_d;
  logic      err_d;

  // one-shot load on the first edge after internal reset release
  assign load_en = ~cfg_done;

  always_comb begin
    err_d = (br_in_n[0] == br_in_n[1]);
    id_d  = agent_id_t'(~br_in_n[1] & br_in_n[0]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_done <= 1'b0;
      agent_id <= '0;
      cfg_err  <= 1'b0;
    end else if (load_en) begin
      cfg_done <= 1'b1;
      agent_id <= id_d;
      cfg_err  <= err_d;
    end
  end
endmodule

// File: rtl/sba_rr_owner.sv
module sba_rr_owner
  import sba_pkg::*;
#(
  parameter agent_id_t INIT_OWNER = agent_id_t'(N_AGENTS - 1)
) (
  input  logic                clk,
  input  logic                rst_int_n,
  input  logic                en,
  input  logic [N_AGENTS-1:0] line_req,
  output agent_id_t           owner
);
  agent_id_t owner_d;
  agent_id_t other;

  always_comb begin
    other   = ~owner;
    owner_d = owner;
    if (en && !line_req[owner] && line_req[other]) owner_d = other;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) owner <= INIT_OWNER;
    else            owner <= owner_d;
  end
endmodule

// File: rtl/sym_breq_agent.sv
module sym_breq_agent
  import sba_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] br_in_n,
  input  logic       bpri_n,
  input  logic       req_i,
  input  logic       lock_i,
  output logic       br0_drive_n,
  output logic       grant,
  output logic       agent_id,
  output logic       cfg_done,
  output logic       cfg_err,
  output logic       owner_id
);
  logic                rst_int_n;
  agent_id_t           id_q;
  agent_id_t           owner_q;
  logic [N_AGENTS-1:0] line_req;
  logic                lock_act, lock_act_d;
  logic                prio_ok;

  sba_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  sba_id_cfg u_cfg (
    .clk(clk), .rst_int_n(rst_int_n), .br_in_n(br_in_n),
    .cfg_done(cfg_done), .agent_id(id_q), .cfg_err(cfg_err)
  );

  // rotated wiring: shared line k arrives on pin k ^ id
  for (genvar k = 0; k < N_AGENTS; k++) begin : g_line
    assign line_req[k] = ~br_in_n[agent_id_t'(k) ^ id_q];
  end

  sba_rr_owner u_own (
    .clk(clk), .rst_int_n(rst_int_n), .en(cfg_done),
    .line_req(line_req), .owner(owner_q)
  );

  assign prio_ok = bpri_n | (lock_i & lock_act);

  always_comb begin
    grant      = cfg_done & (owner_q == id_q) & line_req[id_q] & req_i & prio_ok;
    lock_act_d = lock_i & (lock_act | grant);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) lock_act <= 1'b0;
    else            lock_act <= lock_act_d;
  end

  assign br0_drive_n = ~(cfg_done & req_i);
  assign agent_id    = id_q;
  assign owner_id    = owner_q;
endmodule

// File: rtl/sba_chk.sv
module sba_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] br_in_n,
  input logic       bpri_n,
  input logic       lock_i,
  input logic       br0_drive_n,
  input logic       grant,
  input logic       agent_id,
  input logic       cfg_done,
  input logic       cfg_err,
  input logic       owner_id
);
  a_r1_quiet_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (br0_drive_n && !grant));

  a_r4_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> ($stable(agent_id) && $stable(cfg_err)));

  a_r7_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && ((owner_id == agent_id) ? !br_in_n[0] : !br_in_n[1]))
      |=> $stable(owner_id));

  a_r8_grant_only_owner: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (owner_id == agent_id && !br_in_n[0] && cfg_done));

  a_r9_prio_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !bpri_n) |-> lock_i);
endmodule

bind sym_breq_agent sba_chk u_chk (
  .clk(clk), .rst_n(rst_n), .br_in_n(br_in_n), .bpri_n(bpri_n),
  .lock_i(lock_i), .br0_drive_n(br0_drive_n), .grant(grant),
  .agent_id(agent_id), .cfg_done(cfg_done), .cfg_err(cfg_err),
  .owner_id(owner_id)
);

// File: tb/sym_breq_agent_tb_top.sv
`timescale 1ns/1ps
module sym_breq_agent_tb_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] br_in_n;
  logic       bpri_n, req_i, lock_i;
  logic       br0_drive_n, grant, agent_id, cfg_done, cfg_err, owner_id;

  logic       slot, cent, other_req, ovr_en;
  logic [1:0] ovr_pins;
  logic [1:0] line;
  int total = 0;
  int bad   = 0;
  int cycles = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sym_breq_agent dut_i (
    .clk(clk), .rst_n(rst_n), .br_in_n(br_in_n), .bpri_n(bpri_n),
    .req_i(req_i), .lock_i(lock_i), .br0_drive_n(br0_drive_n),
    .grant(grant), .agent_id(agent_id), .cfg_done(cfg_done),
    .cfg_err(cfg_err), .owner_id(owner_id)
  );

  // board model: wired lines, rotated onto the DUT pins by its slot
  always_comb begin
    line        = 2'b00;
    line[slot]  = ~br0_drive_n;
    line[~slot] = other_req;
    line[0]     = line[0] | cent;
    if (ovr_en) br_in_n = ovr_pins;
    else        br_in_n = {~line[~slot], ~line[slot]};
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_config(logic s, logic c, logic oe, logic [1:0] op,
                           logic exp_id, logic exp_err);
    @(negedge clk);
    rst_n = 1'b0; slot = s; cent = c; ovr_en = oe; ovr_pins = op;
    other_req = 1'b0; bpri_n = 1'b1; lock_i = 1'b0; req_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 drive in reset", br0_drive_n, 1'b1);
    check("R1 grant in reset", grant, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 not done after 2 edges", cfg_done, 1'b0);
    check("R1 drive before cfg", br0_drive_n, 1'b1);
    req_i = 1'b0;
    @(negedge clk);
    check("R2 done after 3 edges", cfg_done, 1'b1);
    check("R2/R3 agent_id", agent_id, exp_id);
    check("R3 cfg_err", cfg_err, exp_err);
    check("R6 initial owner", owner_id, 1'b1);
    cent = 1'b0; ovr_en = 1'b0;
  endtask

  task automatic t_rr_slot0();
    do_config(1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0);
    req_i = 1'b1; #1;
    check("R5 drive follows req", br0_drive_n, 1'b0);
    check("R8 no grant before ownership", grant, 1'b0);
    @(negedge clk);
    check("R7 pass to requester", owner_id, 1'b0);
    check("R8 grant as owner", grant, 1'b1);
    other_req = 1'b1;
    @(negedge clk);
    check("R7 owner keeps while requesting", owner_id, 1'b0);
    check("R8 grant held", grant, 1'b1);
    req_i = 1'b0;
    @(negedge clk);
    check("R7 pass on release", owner_id, 1'b1);
    req_i = 1'b1; #1;
    check("R8 no grant when not owner", grant, 1'b0);
    @(negedge clk);
    check("R7 other keeps bus", owner_id, 1'b1);
    other_req = 1'b0;
    @(negedge clk);
    check("R7 back to us", owner_id, 1'b0);
    req_i = 1'b0;
    @(negedge clk);
    check("R7 hold when idle", owner_id, 1'b0);
  endtask

  task automatic t_prio_lock();
    bpri_n = 1'b0; req_i = 1'b1; #1;
    check("R9 priority blocks", grant, 1'b0);
    bpri_n = 1'b1; #1;
    check("R9 released priority", grant, 1'b1);
    lock_i = 1'b1;
    @(negedge clk);
    bpri_n = 1'b0; #1;
    check("R10 started lock passes priority", grant, 1'b1);
    lock_i = 1'b0; #1;
    check("R10 unlocked blocked", grant, 1'b0);
    @(negedge clk);
    lock_i = 1'b1; #1;
    check("R10 new lock blocked", grant, 1'b0);
    @(negedge clk);
    check("R10 still blocked", grant, 1'b0);
    bpri_n = 1'b1; lock_i = 1'b0; req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_slot1();
    do_config(1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0);
    req_i = 1'b1; #1;
    check("R8 immediate grant as initial owner", grant, 1'b1);
    check("R5 own line on pin0", br_in_n[0], 1'b0);
    req_i = 1'b0; other_req = 1'b1;
    @(negedge clk);
    check("R5 other line on pin1 moves owner", owner_id, 1'b0);
    other_req = 1'b0;
    @(negedge clk);
    check("R4 id kept", agent_id, 1'b1);
  endtask

  task automatic t_cfg_err();
    do_config(1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1);
    do_config(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    ovr_en = 1'b1; ovr_pins = 2'b01;
    repeat (2) @(negedge clk);
    check("R4 id ignores pins", agent_id, 1'b0);
    check("R4 err ignores pins", cfg_err, 1'b1);
    ovr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; slot = 1'b0; cent = 1'b0; other_req = 1'b0;
    ovr_en = 1'b0; ovr_pins = 2'b11; bpri_n = 1'b1; req_i = 1'b0; lock_i = 1'b0;
    @(negedge clk);
    check("R1 cfg_done in reset", cfg_done, 1'b0);
    t_rr_slot0();
    t_prio_lock();
    t_slot1();
    t_cfg_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule